// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Complete

This block gathers level-sensitive interrupt inputs and routes them to a small set of targets. Each hart has two targets: one for machine mode and one for supervisor mode. For every source the block keeps a 3-bit priority, a pending bit and a claimed bit. For every target it keeps an enable bitmap, a priority threshold and a claim/complete port. Software reaches all of this through a simple 32-bit register bus.

Software reads a target's claim register to take ownership of the highest-priority eligible source. When its handler is done, it writes the same source ID back to the claim register. A compile-time parameter picks how the per-target lines are delivered. In one variant they drive the external-interrupt lines of each hart. In the other they drive the software (inter-processor) interrupt lines.

Top module: `plic_claim_ctrl`

## Requirements
- R1: The priority of source n (n ≥ 1) is read and written at byte address 0x4 + 4·(n−1). Only the low 3 bits of a written value are kept, and a read returns them zero-extended. Source 0 has no priority register, its pending bit always reads 0, and it is never returned by a claim.
- R2: Pending word w sits at 0x1000 + 4·w, and bit b of that word holds source 32·w + b. A write ORs the data into the pending bits, so software can set a pending bit but can never clear one.
- R3: Target t's enable word w sits at 0x2000 + 0x80·t + 4·w, and bit b holds source 32·w + b. The word reads back as it was written.
- R4: When a source input changes level, its pending bit takes the new level on the next clock edge: a rise sets the bit and a fall clears it.
- R5: A target's line is high exactly when some source is pending, enabled for that target, not claimed, and has a priority strictly above the target's threshold. The line follows that condition one clock later.
- R6: Reading 0x200000 + 0x1000·t + 4 returns the eligible source with the highest priority above the threshold, with ties going to the lowest ID, or 0 if no source qualifies. A non-zero claim clears that source's pending bit and sets its claimed bit.
- R7: Writing an ID below NUM_SRC to a target's claim register clears that source's claimed bit. A write of NUM_SRC or more has no effect.
- R8: The threshold of target t sits at 0x200000 + 0x1000·t and reads back as written. A write with a value above PRIO_MAX is ignored.
- R9: Target 2h is hart h in machine mode and target 2h+1 is hart h in supervisor mode. With SW_IPI=0 they drive m_ext_irq_o[h] and s_ext_irq_o[h], and both software lines stay 0. With SW_IPI=1 they drive m_sw_irq_o[h] and s_sw_irq_o[h], and both external lines stay 0.
- R10: A read of an unmapped or misaligned address returns 0, and a write to one has no effect.
- R11: Read data appears on rdata_o together with a one-cycle rvalid_o pulse in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt inputs (bit 0 unused) |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| m_ext_irq_o | output | NUM_HART | Machine external interrupt per hart |
| s_ext_irq_o | output | NUM_HART | Supervisor external interrupt per hart |
| m_sw_irq_o | output | NUM_HART | Machine software interrupt per hart |
| s_sw_irq_o | output | NUM_HART | Supervisor software interrupt per hart |

## Verification
The main instance is built with NUM_SRC=40, NUM_HART=1, PRIO_MAX=7 and SW_IPI=0. Forty sources span two pending and enable words, and the second word is only partly populated, so both the word-boundary decode and the out-of-window enable word can be reached. One hart still gives both a machine and a supervisor target, which exercises target ordering and per-target thresholds. A second instance with NUM_SRC=8 and SW_IPI=1 shows that the same routing drives the software lines and leaves the external lines quiet.

// File: rtl/plic_pkg.sv
package plic_pkg;
  typedef logic [2:0] prio_t;

  localparam int unsigned PRIO_BASE  = 32'h0000_0004;
  localparam int unsigned PEND_BASE  = 32'h0000_1000;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned TGT_BASE   = 32'h0020_0000;
  localparam int unsigned TGT_STRIDE = 32'h0000_1000;
  localparam int unsigned CLAIM_OFS  = 32'h0000_0004;
endpackage

// File: rtl/plic_arbiter.sv
module plic_arbiter
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 48,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] elig_i,
  input  prio_t              prio_i [NUM_SRC],
  input  prio_t              thr_i,
  output logic [IDW-1:0]     id_o,
  output prio_t              prio_o
);
  // downward scan with >= lets the lower ID win a tie
  always_comb begin
    id_o   = '0;
    prio_o = thr_i;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (elig_i[i] && (prio_i[i] > thr_i) && (prio_i[i] >= prio_o)) begin
        id_o   = IDW'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/plic_claim_ctrl.sv
module plic_claim_ctrl
  import plic_pkg::*;
#(
  parameter int NUM_SRC  = 48,
  parameter int NUM_HART = 1,
  parameter int PRIO_MAX = 7,
  parameter bit SW_IPI   = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [31:0]         addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  output logic [NUM_HART-1:0] m_ext_irq_o,
  output logic [NUM_HART-1:0] s_ext_irq_o,
  output logic [NUM_HART-1:0] m_sw_irq_o,
  output logic [NUM_HART-1:0] s_sw_irq_o
);
  localparam int NUM_TGT = 2 * NUM_HART;
  localparam int IDW     = $clog2(NUM_SRC);

  prio_t              prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] pend_q, pend_d, clm_q, clm_d, src_q;
  logic [NUM_SRC-1:0] en_q   [NUM_TGT];
  prio_t              thr_q  [NUM_TGT];
  logic [NUM_TGT-1:0] irq_q;
  logic [IDW-1:0]     best_id   [NUM_TGT];
  prio_t              best_prio [NUM_TGT];

  logic rd_en, wr_en, aligned;
  logic claim_fire, done_hit;
  logic [IDW-1:0] claim_id;
  logic [31:0] rd_data;

  assign rd_en   = req_i && !we_i;
  assign wr_en   = req_i && we_i;
  assign aligned = (addr_i[1:0] == 2'b00);

  // per-target arbitration
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    plic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .elig_i (pend_q & ~clm_q & en_q[t]),
      .prio_i (prio_q),
      .thr_i  (thr_q[t]),
      .id_o   (best_id[t]),
      .prio_o (best_prio[t])
    );

    AST_ARB_ABOVE_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (best_id[t] != '0) |-> (best_prio[t] > thr_q[t])); // R5
    AST_THR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr_q[t] <= prio_t'(PRIO_MAX)); // R8
  end

  // read mux and claim/complete decode
  always_comb begin
    rd_data    = '0;
    claim_fire = 1'b0;
    claim_id   = '0;
    done_hit   = 1'b0;
    if (aligned) begin
      for (int s = 1; s < NUM_SRC; s++)
        if (addr_i == 32'(PRIO_BASE + 4 * (s - 1))) rd_data = {29'b0, prio_q[s]};
      for (int s = 0; s < NUM_SRC; s++)
        if (addr_i == 32'(PEND_BASE + 4 * (s / 32))) rd_data[s % 32] = pend_q[s];
      for (int t = 0; t < NUM_TGT; t++) begin
        for (int s = 0; s < NUM_SRC; s++)
          if (addr_i == 32'(EN_BASE + EN_STRIDE * t + 4 * (s / 32)))
            rd_data[s % 32] = en_q[t][s];
        if (addr_i == 32'(TGT_BASE + TGT_STRIDE * t)) rd_data = {29'b0, thr_q[t]};
        if (addr_i == 32'(TGT_BASE + TGT_STRIDE * t + CLAIM_OFS)) begin
          rd_data    = 32'(best_id[t]);
          claim_fire = rd_en && (best_id[t] != '0);
          claim_id   = best_id[t];
          done_hit   = wr_en;
        end
      end
    end
  end

  // pending and claimed next state
  always_comb begin
    pend_d = pend_q;
    clm_d  = clm_q;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_i[s] != src_q[s]) pend_d[s] = src_i[s];
    if (wr_en && aligned)
      for (int s = 0; s < NUM_SRC; s++)
        if (addr_i == 32'(PEND_BASE + 4 * (s / 32)) && wdata_i[s % 32]) pend_d[s] = 1'b1;
    if (claim_fire) begin
      pend_d[claim_id] = 1'b0;
      clm_d[claim_id]  = 1'b1;
    end
    if (done_hit && (wdata_i < 32'(NUM_SRC))) clm_d[wdata_i[IDW-1:0]] = 1'b0;
    pend_d[0] = 1'b0;
    clm_d[0]  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      pend_q   <= '0;
      clm_q    <= '0;
      irq_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
      for (int t = 0; t < NUM_TGT; t++) begin
        en_q[t]  <= '0;
        thr_q[t] <= '0;
      end
    end else begin
      src_q    <= src_i;
      pend_q   <= pend_d;
      clm_q    <= clm_d;
      rvalid_o <= rd_en;
      if (rd_en) rdata_o <= rd_data;
      for (int t = 0; t < NUM_TGT; t++) irq_q[t] <= (best_id[t] != '0);
      if (wr_en && aligned) begin
        for (int s = 1; s < NUM_SRC; s++)
          if (addr_i == 32'(PRIO_BASE + 4 * (s - 1))) prio_q[s] <= wdata_i[2:0];
        for (int t = 0; t < NUM_TGT; t++) begin
          for (int s = 0; s < NUM_SRC; s++)
            if (addr_i == 32'(EN_BASE + EN_STRIDE * t + 4 * (s / 32)))
              en_q[t][s] <= wdata_i[s % 32];
          if (addr_i == 32'(TGT_BASE + TGT_STRIDE * t) && wdata_i <= 32'(PRIO_MAX))
            thr_q[t] <= wdata_i[2:0];
        end
      end
    end
  end

  // line routing per hart
  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    if (SW_IPI) begin : g_sw
      assign m_sw_irq_o[h]  = irq_q[2*h];
      assign s_sw_irq_o[h]  = irq_q[2*h+1];
      assign m_ext_irq_o[h] = 1'b0;
      assign s_ext_irq_o[h] = 1'b0;
    end else begin : g_ext
      assign m_ext_irq_o[h] = irq_q[2*h];
      assign s_ext_irq_o[h] = irq_q[2*h+1];
      assign m_sw_irq_o[h]  = 1'b0;
      assign s_sw_irq_o[h]  = 1'b0;
    end
  end

  AST_SRC0_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[0] && !clm_q[0]); // R1
  AST_CLAIM_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_fire |=> (clm_q[$past(claim_id)] && !pend_q[$past(claim_id)])); // R6
  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o); // R11
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rvalid_o); // R11
endmodule

// File: tb/plic_claim_ctrl_bench.sv
`timescale 1ns/1ps
module plic_claim_ctrl_bench;
  localparam int NS = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NS-1:0] src = '0;
  logic [7:0]    src2 = '0;
  logic req = 0, req2 = 0, we = 0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata, rdata2;
  logic rvalid, rvalid2;
  logic [0:0] meip, seip, msip, ssip, meip2, seip2, msip2, ssip2;

  int total = 0, bad = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  plic_claim_ctrl #(.NUM_SRC(NS), .NUM_HART(1), .PRIO_MAX(7), .SW_IPI(1'b0)) u_plic_claim_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .m_ext_irq_o(meip),
    .s_ext_irq_o(seip), .m_sw_irq_o(msip), .s_sw_irq_o(ssip));

  plic_claim_ctrl #(.NUM_SRC(8), .NUM_HART(1), .PRIO_MAX(7), .SW_IPI(1'b1)) u_plic_sw (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src2), .req_i(req2), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata2), .rvalid_o(rvalid2), .m_ext_irq_o(meip2),
    .s_ext_irq_o(seip2), .m_sw_irq_o(msip2), .s_sw_irq_o(ssip2));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each returned read
  always @(negedge clk) begin
    if (rvalid) begin
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected rvalid act=%h exp=none", rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(rdata, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    req = 1; we = 0; addr = a;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    req = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit second = 0);
    @(negedge clk);
    if (second) req2 = 1; else req = 1;
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; req2 = 0; we = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL R11 missing reads act=%0d exp=0", sbq.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // reset state
    chk({31'b0, meip[0]}, 0, "R5 reset meip");
    chk({31'b0, seip[0]}, 0, "R9 reset seip");
    rd(32'h4, 0, "R1 reset prio");
    rd(32'h1000, 0, "R2 reset pending");
    rd(32'h200004, 0, "R6 empty claim");

    // R1 priority truncation
    wr(32'hC, 32'hFF);
    rd(32'hC, 7, "R1 prio 3 bits");
    wr(32'h4 + 4*4, 3);   // src5
    wr(32'h4 + 4*8, 3);   // src9
    wr(32'h4 + 4*34, 6);  // src35
    wr(32'h2000, 32'h220);
    wr(32'h2004, 32'h8);
    rd(32'h2004, 32'h8, "R3 enable word1");
    rd(32'h2000, 32'h220, "R3 enable word0");
    rd(32'h2008, 0, "R10 enable beyond window");

    // R4 level raise
    src[5] = 1; src[9] = 1;
    settle();
    rd(32'h1000, 32'h220, "R4 pending set by level");
    chk({31'b0, meip[0]}, 1, "R5 meip on");
    chk({31'b0, seip[0]}, 0, "R9 seip stays off");
    chk({30'b0, msip[0], ssip[0]}, 0, "R9 sw lines off in ext variant");

    // R8 threshold
    wr(32'h200000, 3);
    settle();
    chk({31'b0, meip[0]}, 0, "R5 prio equal to threshold");
    wr(32'h200000, 8);
    rd(32'h200000, 3, "R8 threshold write over max ignored");
    wr(32'h200000, 2);
    settle();
    chk({31'b0, meip[0]}, 1, "R5 above threshold");

    // R6 claims
    rd(32'h200004, 5, "R6 tie goes to lowest id");
    rd(32'h1000, 32'h200, "R6 claim clears pending");
    rd(32'h200004, 9, "R6 second claim");
    rd(32'h200004, 0, "R6 nothing left");
    settle();
    chk({31'b0, meip[0]}, 0, "R5 claimed sources quiet");

    // R7 complete
    src[5] = 0; settle(); src[5] = 1; settle();
    chk({31'b0, meip[0]}, 0, "R5 pending but claimed");
    wr(32'h200004, 69);
    settle();
    chk({31'b0, meip[0]}, 0, "R7 out-of-range id ignored");
    wr(32'h200004, 5);
    settle();
    chk({31'b0, meip[0]}, 1, "R7 complete re-arms");
    rd(32'h200004, 5, "R7 reclaim");
    wr(32'h200004, 5);
    wr(32'h200004, 9);

    // R2 software pending
    wr(32'h1004, 32'h8);
    rd(32'h1004, 32'h8, "R2 sw set word1");
    settle();
    chk({31'b0, meip[0]}, 1, "R5 sw pending raises");
    rd(32'h200004, 35, "R6 highest priority wins");
    wr(32'h200004, 35);

    // R4 level fall
    src[12] = 1; settle();
    rd(32'h1000, 32'h1000, "R4 rise on unenabled src");
    src[12] = 0; settle();
    rd(32'h1000, 0, "R4 fall clears pending");

    wr(32'h1000, 32'h81);
    rd(32'h1000, 32'h80, "R1 src0 pending never set");
    wr(32'h1000, 32'h0);
    rd(32'h1000, 32'h80, "R2 write cannot clear");

    // R9 supervisor target
    wr(32'h2080, 32'h80);
    settle();
    chk({31'b0, seip[0]}, 0, "R5 prio 0 never signals");
    wr(32'h4 + 4*6, 1);
    settle();
    chk({31'b0, seip[0]}, 1, "R9 supervisor target line");
    chk({31'b0, meip[0]}, 0, "R9 machine target unaffected");
    rd(32'h201004, 7, "R9 claim via target 1");
    settle();
    chk({31'b0, seip[0]}, 0, "R9 seip drops after claim");

    // R10 decode holes
    rd(32'h800, 0, "R10 unmapped read");
    rd(32'hE, 0, "R10 misaligned read");
    wr(32'hD, 5);
    rd(32'hC, 7, "R10 misaligned write ignored");

    // R9 software variant
    wr(32'h4, 2, 1);
    wr(32'h2000, 32'h2, 1);
    src2[1] = 1;
    settle();
    chk({31'b0, msip2[0]}, 1, "R9 sw variant msip");
    chk({31'b0, meip2[0]}, 0, "R9 sw variant meip quiet");
    chk({31'b0, ssip2[0]}, 0, "R9 sw variant ssip");

    finish_run();
  end
endmodule